// File: doc/BRIEF.md
# Expansion ROM Window Decoder

This block is one slice of a device's configuration space. It keeps a host-programmable base address for an optional expansion ROM and checks each bus address phase against that base. When the window is enabled and a memory read command's address falls inside the window, the block raises a one-bit claim for the bus engine to use. The same slice also answers configuration reads with a constant capabilities pointer, a host-writable interrupt routing byte, a constant interrupt pin byte and a constant minimum-grant byte.

The ROM size is set by a static writable-bit mask. A mask bit of 1 makes the matching base bit, address bits 23 down to 11, writable and part of the address compare. A mask bit of 0 fixes that base bit at zero and removes the address bit from the compare, which widens the window. A separate static permission input decides whether the ROM may be mapped at all. Configuration reads are registered and return data one clock after the read strobe.

Top module: `xrom_cfg_slice`

## Requirements
- R1: Bits 31:24 of the ROM base register (dword offset 0x0C) are always writable through byte lane 3 and read back as written.
- R2: Base bit 11+i (i = 0..12) is written from write-data bit 11+i only when rom_wmask[i] is 1. A bit whose mask is 0 reads back as 0.
- R3: Bits 10:1 of the ROM base register always read as 0. Writes to them have no effect.
- R4: Bit 0 of the ROM base register is the ROM enable. It can be written through byte lane 0 only while rom_allow is 1, and it reads as 0 whenever rom_allow is 0.
- R5: claim is 1 only in these cases: ap_valid, mem_en and the ROM enable are all 1; ap_cmd is 4'b0110, 4'b1100 or 4'b1110; ap_addr_hi[20:13] equals base bits 31:24; and for every i with rom_wmask[i]=1, ap_addr_hi[i] equals base bit 11+i. claim follows its inputs combinationally.
- R6: A synchronous hard reset (rst=1) clears the base bits, the ROM enable, the interrupt line byte and the read data register.
- R7: Dword offset 0x0D reads as 0x00000044. Writes to it have no effect.
- R8: Dword offset 0x0F reads as {8'h00, MIN_GNT_VAL (default 8'h18), 8'h01, line}. Byte 0 (line) is host read/write and does not change claim. The other bytes ignore writes.
- R9: A configuration write changes only the byte lanes whose cfg_be bit is 1.
- R10: Reads of any other dword offset return 0, and writes to those offsets change nothing. cfg_rdata is loaded on the clock edge where cfg_rd is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| rom_wmask | input | 13 | Writable and compared mask for base bits 23:11 |
| rom_allow | input | 1 | Permits the ROM enable bit to be set |
| mem_en | input | 1 | Memory space enable from the command register |
| ap_valid | input | 1 | Address phase present |
| ap_cmd | input | 4 | Bus command of the address phase |
| ap_addr_hi | input | 21 | Address bits 31:11 of the address phase |
| claim | output | 1 | Address phase hits the ROM window |

## Verification
The bench tries several mask patterns with permission both on and off. For each one it flips every compared address bit one at a time. A decoder that compared a masked-off bit would fail to claim a wider window, and one that ignored an enabled bit would claim addresses outside the window. Every command code is tried, with mem_en and ap_valid both on and off, to catch claims on writes or on disabled memory space. The bench also sweeps all byte-enable patterns, writes to the read-only bytes and to unused offsets, reads every dword offset, and applies a mid-run hard reset. Lane mixups, writable constants and stale enable bits all show up as read-back mismatches.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int ADDR_W  = 32;
  localparam int ROM_LSB = 11;
  localparam int FIX_LSB = 24;
  localparam int VAR_W   = FIX_LSB - ROM_LSB;
  localparam int FIX_W   = ADDR_W - FIX_LSB;
  localparam int HI_W    = ADDR_W - ROM_LSB;
  localparam int OFF_W   = 6;
  localparam int BE_W    = ADDR_W / 8;

  localparam logic [OFF_W-1:0] ROM_DW = 6'h0C;
  localparam logic [OFF_W-1:0] CAP_DW = 6'h0D;
  localparam logic [OFF_W-1:0] IRQ_DW = 6'h0F;

  localparam logic [3:0] CMD_MRD  = 4'b0110;
  localparam logic [3:0] CMD_MRDM = 4'b1100;
  localparam logic [3:0] CMD_MRDL = 4'b1110;

  function automatic logic is_mem_read(input logic [3:0] cmd);
    return (cmd == CMD_MRD) || (cmd == CMD_MRDM) || (cmd == CMD_MRDL);
  endfunction
endpackage

// File: rtl/xrom_base_reg.sv
module xrom_base_reg
  import xrom_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [BE_W-1:0]  be,
  input  logic [FIX_W-1:0] wr_fix,
  input  logic [VAR_W-1:0] wr_var,
  input  logic             wr_en_bit,
  input  logic [VAR_W-1:0] wmask,
  input  logic             allow,
  output logic [FIX_W-1:0] base_fix,
  output logic [VAR_W-1:0] base_var,
  output logic             rom_en
);
  logic [FIX_W-1:0] fix_q, fix_we;
  logic [VAR_W-1:0] var_q, var_we;
  logic             en_q;

  // per-bit lane enables: each bit follows the byte lane it sits in
  for (genvar j = 0; j < FIX_W; j++) begin : g_fix_lane
    localparam int LANE = (FIX_LSB + j) / 8;
    assign fix_we[j] = be[LANE];
  end
  for (genvar i = 0; i < VAR_W; i++) begin : g_var_lane
    localparam int LANE = (ROM_LSB + i) / 8;
    assign var_we[i] = be[LANE] & wmask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_q <= '0;
      var_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_sel) begin
      fix_q <= (fix_q & ~fix_we) | (wr_fix & fix_we);
      var_q <= (var_q & ~var_we) | (wr_var & var_we);
      if (be[0] && allow) en_q <= wr_en_bit;
    end
  end

  assign base_fix = fix_q;
  assign base_var = var_q & wmask;
  assign rom_en   = en_q & allow;

  a_r2_locked_bits_hold: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (((var_q ^ $past(var_q)) & ~$past(wmask)) == '0));
  a_r4_enable_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && !allow) |=> $stable(en_q));
  a_r9_no_lanes_no_change: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && be == '0) |=> ($stable(fix_q) && $stable(var_q) && $stable(en_q)));
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(fix_q));
endmodule

// File: rtl/xrom_window_match.sv
module xrom_window_match
  import xrom_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ap_valid,
  input  logic [3:0]       ap_cmd,
  input  logic [HI_W-1:0]  ap_addr_hi,
  input  logic             mem_en,
  input  logic             rom_en,
  input  logic [FIX_W-1:0] base_fix,
  input  logic [VAR_W-1:0] base_var,
  input  logic [VAR_W-1:0] wmask,
  output logic             claim
);
  logic fix_hit, var_hit, gate;

  assign fix_hit = (ap_addr_hi[HI_W-1:VAR_W] == base_fix);
  assign var_hit = (((ap_addr_hi[VAR_W-1:0] ^ base_var) & wmask) == '0);
  assign gate    = ap_valid & mem_en & rom_en & is_mem_read(ap_cmd);
  assign claim   = gate & fix_hit & var_hit;

  a_r5_claim_needs_enables: assert property (@(posedge clk) disable iff (rst)
    claim |-> (mem_en && rom_en && ap_valid));
  a_r5_claim_top_bits: assert property (@(posedge clk) disable iff (rst)
    claim |-> (ap_addr_hi[HI_W-1:VAR_W] == base_fix));
endmodule

// File: rtl/xrom_cfg_bytes.sv
module xrom_cfg_bytes
  import xrom_pkg::*;
#(
  parameter logic [7:0] CAP_PTR_VAL = 8'h44,
  parameter logic [7:0] INT_PIN_VAL = 8'h01,
  parameter logic [7:0] MIN_GNT_VAL = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic              be0,
  input  logic [7:0]        wr_byte0,
  input  logic [ADDR_W-1:0] base_rd,
  output logic [ADDR_W-1:0] rdata
);
  logic [7:0]        irq_line_q;
  logic [ADDR_W-1:0] rd_mux;
  logic              line_we;

  assign line_we = cfg_wr && (cfg_addr == IRQ_DW) && be0;

  always_ff @(posedge clk) begin
    if (rst)          irq_line_q <= '0;
    else if (line_we) irq_line_q <= wr_byte0;
  end

  always_comb begin
    case (cfg_addr)
      ROM_DW:  rd_mux = base_rd;
      CAP_DW:  rd_mux = {24'h0, CAP_PTR_VAL};
      IRQ_DW:  rd_mux = {8'h00, MIN_GNT_VAL, INT_PIN_VAL, irq_line_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cfg_rd) rdata <= rd_mux;
  end

  a_r8_line_hold: assert property (@(posedge clk) disable iff (rst)
    !line_we |=> $stable(irq_line_q));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(rdata));
endmodule

// File: rtl/xrom_cfg_slice.sv
module xrom_cfg_slice
  import xrom_pkg::*;
#(
  parameter logic [7:0] CAP_PTR_VAL = 8'h44,
  parameter logic [7:0] INT_PIN_VAL = 8'h01,
  parameter logic [7:0] MIN_GNT_VAL = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [VAR_W-1:0]  rom_wmask,
  input  logic              rom_allow,
  input  logic              mem_en,
  input  logic              ap_valid,
  input  logic [3:0]        ap_cmd,
  input  logic [HI_W-1:0]   ap_addr_hi,
  output logic              claim
);
  logic [FIX_W-1:0]  base_fix;
  logic [VAR_W-1:0]  base_var;
  logic              rom_en;
  logic [ADDR_W-1:0] base_rd;
  logic              base_sel;
  logic              unused_wbits;

  assign base_sel     = cfg_wr && (cfg_addr == ROM_DW);
  assign unused_wbits = ^cfg_wdata[ROM_LSB-1:8];
  assign base_rd      = {base_fix, base_var, {(ROM_LSB-1){1'b0}}, rom_en};

  xrom_base_reg u_base (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (base_sel),
    .be        (cfg_be),
    .wr_fix    (cfg_wdata[ADDR_W-1:FIX_LSB]),
    .wr_var    (cfg_wdata[FIX_LSB-1:ROM_LSB]),
    .wr_en_bit (cfg_wdata[0]),
    .wmask     (rom_wmask),
    .allow     (rom_allow),
    .base_fix  (base_fix),
    .base_var  (base_var),
    .rom_en    (rom_en)
  );

  xrom_window_match u_match (
    .clk        (clk),
    .rst        (rst),
    .ap_valid   (ap_valid),
    .ap_cmd     (ap_cmd),
    .ap_addr_hi (ap_addr_hi),
    .mem_en     (mem_en),
    .rom_en     (rom_en),
    .base_fix   (base_fix),
    .base_var   (base_var),
    .wmask      (rom_wmask),
    .claim      (claim)
  );

  xrom_cfg_bytes #(
    .CAP_PTR_VAL (CAP_PTR_VAL),
    .INT_PIN_VAL (INT_PIN_VAL),
    .MIN_GNT_VAL (MIN_GNT_VAL)
  ) u_bytes (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .be0      (cfg_be[0]),
    .wr_byte0 (cfg_wdata[7:0]),
    .base_rd  (base_rd),
    .rdata    (cfg_rdata)
  );

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rd && cfg_addr == ROM_DW) |-> (cfg_rdata[ROM_LSB-1:1] == '0));
  a_r7_cap_constant: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rd && cfg_addr == CAP_DW) |-> (cfg_rdata == {24'h0, CAP_PTR_VAL}));
endmodule

// File: tb/xrom_cfg_slice_bench.sv
module xrom_cfg_slice_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [12:0] rom_wmask = '0;
  logic        rom_allow = 1'b0;
  logic        mem_en = 1'b0, ap_valid = 1'b0;
  logic [3:0]  ap_cmd = '0;
  logic [20:0] ap_addr_hi = '0;
  logic        claim;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_fix = '0;
  logic [12:0] m_var = '0;
  logic        m_en = 1'b0;
  logic [7:0]  m_line = '0;

  always #5 clk = ~clk;

  xrom_cfg_slice u_xrom_cfg_slice (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rom_wmask(rom_wmask), .rom_allow(rom_allow), .mem_en(mem_en),
    .ap_valid(ap_valid), .ap_cmd(ap_cmd), .ap_addr_hi(ap_addr_hi), .claim(claim)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h0C:   return {m_fix, m_var & rom_wmask, 10'b0, m_en & rom_allow};
      6'h0D:   return 32'h0000_0044;
      6'h0F:   return {8'h00, 8'h18, 8'h01, m_line};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_claim();
    return ap_valid && mem_en && m_en && rom_allow &&
           (ap_cmd == 4'b0110 || ap_cmd == 4'b1100 || ap_cmd == 4'b1110) &&
           (ap_addr_hi[20:13] == m_fix) &&
           (((ap_addr_hi[12:0] ^ m_var) & rom_wmask) == 13'h0);
  endfunction

  task automatic do_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 6'h0C) begin
      if (be[3]) m_fix = d[31:24];
      for (int i = 0; i < 13; i++)
        if (be[(11 + i) / 8] && rom_wmask[i]) m_var[i] = d[11 + i];
      if (be[0] && rom_allow) m_en = d[0];
    end
    if (a == 6'h0F && be[0]) m_line = d[7:0];
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(req, cfg_rdata, exp_rd(a));
  endtask

  task automatic claim_chk(input string req, input logic v, input logic me,
                           input logic [3:0] cmd, input logic [20:0] ah);
    @(negedge clk);
    ap_valid = v; mem_en = me; ap_cmd = cmd; ap_addr_hi = ah;
    #1;
    chk(req, {31'b0, claim}, {31'b0, exp_claim()});
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_fix = '0; m_var = '0; m_en = 1'b0; m_line = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] masks [5];
    logic [20:0] hit;
    masks[0] = 13'h1FFF; masks[1] = 13'h0000; masks[2] = 13'h1555;
    masks[3] = 13'h0AAA; masks[4] = 13'h1F00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6 / R7 / R8 / R10: reset state across every offset
    rom_wmask = 13'h1FFF; rom_allow = 1'b1;
    for (int a = 0; a < 64; a++) rd_chk("R6 R10 reset readback", 6'(a));
    claim_chk("R6 no claim after reset", 1'b1, 1'b1, 4'b0110, 21'h0);

    for (int mi = 0; mi < 5; mi++) begin
      for (int al = 0; al < 2; al++) begin
        rom_wmask = masks[mi]; rom_allow = al[0];
        do_wr(6'h0C, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R1 R2 R3 R4 all ones", 6'h0C);
        do_wr(6'h0C, 4'hF, 32'h0000_0000);
        rd_chk("R2 R4 all zeros", 6'h0C);
        do_wr(6'h0C, 4'hF, 32'h9C00_0001 | (32'(13'h0B5A) << 11));
        rd_chk("R1 R2 R4 pattern", 6'h0C);
        hit = {m_fix, m_var & rom_wmask};
        claim_chk("R5 exact hit", 1'b1, 1'b1, 4'b0110, hit);
        for (int k = 0; k < 21; k++)
          claim_chk("R5 flipped address bit", 1'b1, 1'b1, 4'b1100, hit ^ (21'h1 << k));
        for (int c = 0; c < 16; c++) begin
          claim_chk("R5 command sweep", 1'b1, 1'b1, 4'(c), hit);
          claim_chk("R5 mem_en off", 1'b1, 1'b0, 4'(c), hit);
          claim_chk("R5 no address phase", 1'b0, 1'b1, 4'(c), hit);
        end
      end
    end

    // R8: line byte has no effect on claim
    rom_wmask = 13'h1FFF; rom_allow = 1'b1;
    do_wr(6'h0C, 4'hF, 32'hA000_0801);
    hit = {m_fix, m_var};
    do_wr(6'h0F, 4'hF, 32'hFFFF_FF5A);
    rd_chk("R8 line write, constants kept", 6'h0F);
    claim_chk("R8 line has no effect on claim", 1'b1, 1'b1, 4'b1110, hit);

    // R9: byte-enable sweep
    for (int b = 0; b < 16; b++) begin
      do_wr(6'h0C, 4'hF, 32'h1234_5801);
      do_wr(6'h0C, 4'(b), 32'hEDCB_A7FE);
      rd_chk("R9 base lanes", 6'h0C);
      do_wr(6'h0F, 4'(b), 32'h5566_7700 | 32'(b));
      rd_chk("R9 line lane", 6'h0F);
    end

    // R7 / R10: writes to read-only or empty offsets
    do_wr(6'h0D, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R7 cap pointer after write", 6'h0D);
    do_wr(6'h0E, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R10 empty offset after write", 6'h0E);
    rd_chk("R10 base untouched", 6'h0C);

    // R3: low bits
    do_wr(6'h0C, 4'hF, 32'h0000_07FE);
    rd_chk("R3 low bits ignore writes", 6'h0C);

    // R10: read data holds without a read strobe
    rd_chk("R10 load cap", 6'h0D);
    do_wr(6'h0C, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 rdata holds", cfg_rdata, 32'h0000_0044);

    // R6: mid-run hard reset
    do_wr(6'h0F, 4'h1, 32'h0000_00C3);
    hard_reset();
    rd_chk("R6 base cleared", 6'h0C);
    rd_chk("R6 line cleared", 6'h0F);
    claim_chk("R6 no claim", 1'b1, 1'b1, 4'b0110, 21'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule